// File: doc/BRIEF.md
# Interrupt Pending Controller with Scrambled Source Mapping

This block gathers 64 interrupt request lines into two 32-bit pending registers (upper and lower) with two matching 32-bit enable masks. Each source number is placed in a word and a bit by a fixed, non-arithmetic placement rule, so source N does not sit at bit N. A request line that is high at a clock edge latches its pending bit. The bit stays set until software clears it by writing a one to that bit position.

The block drives an interrupt line to the CPU. It also offers a vector register that reports the lowest nonzero source number that is both pending and enabled. Software reads the vector, services the source and clears its pending bit. Register access uses a simple synchronous write port and a combinational read port.

Top module: `scram_intc`

## Requirements
- R1: While reset is held and after its release, both pending registers and both mask registers read zero, `irq_out` is low and the vector reads zero.
- R2: The word is chosen from the source number. Sources 0–15 and 32–47 go to the upper word, at address 0 for pending and 2 for mask. Sources 16–31 and 48–63 go to the lower word, at address 1 for pending and 3 for mask.
- R3: Bit positions are as follows. Source 0 uses bit 0. Source s in 1–15 uses bit 16−s. Sources 16, 17 and 18 use bits 2, 1 and 0. Source s in 19–30 uses bit 33−s. Source 31 uses bit 0, so sources 18 and 31 share one lower-word bit. Source s in 32–47 uses bit 63−s. Source s in 48–63 uses bit s−32.
- R4: Mask registers read back the last value written. A mask bit of 1 enables its source and 0 blocks it. Pending bits latch whatever the mask holds.
- R5: A write to a pending register clears each bit written as 1 and leaves each bit written as 0 unchanged. All ones clears the whole word.
- R6: A request high for one clock sets its pending bit, which stays set after the request drops.
- R7: `irq_out` is high exactly when some pending bit has its mask bit set, including the bit of source 0.
- R8: The vector register at address 4 carries in bits 31:26 the lowest nonzero source number whose bit is pending and enabled. Its bits 25:0 read zero. A value of 0 means no such source. Addresses 5–7 read zero.
- R9: A request that is high in the same cycle as a clearing write to its bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 64 | Interrupt request per source number |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The assertions check these properties on every cycle:
- a nonzero vector only ever appears with `irq_out` high;
- the low 26 bits of the vector read zero;
- mask writes are stored;
- an all-ones clear empties a word;
- a held request survives a clear in the same cycle.

Only the bench's scenarios can show the following:
- that each of the 64 sources lands in its own word and bit, including the shared bit of sources 18 and 31;
- the lowest-number priority among several active sources;
- that source 0 raises the interrupt line while the vector stays zero.

// File: rtl/scram_intc.sv
module scram_intc #(
  parameter int REG_W = 32,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      src_req,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq_out
);
  localparam int NSRC  = 64;
  localparam int VEC_W = $clog2(NSRC);
  localparam int BIT_W = $clog2(REG_W);

  localparam logic [AW-1:0] A_PEND_HI = AW'(0);
  localparam logic [AW-1:0] A_PEND_LO = AW'(1);
  localparam logic [AW-1:0] A_MASK_HI = AW'(2);
  localparam logic [AW-1:0] A_MASK_LO = AW'(3);
  localparam logic [AW-1:0] A_VECTOR  = AW'(4);

  logic [REG_W-1:0] pend_hi, pend_lo, mask_hi, mask_lo;
  logic [REG_W-1:0] set_hi, set_lo;
  logic [VEC_W-1:0] vec_num;

  function automatic logic in_upper(input int s);
    return (s < 16) || (s >= 32 && s < 48);
  endfunction

  function automatic logic [BIT_W-1:0] bit_of(input int s);
    int b;
    if (s == 0)       b = 0;
    else if (s < 16)  b = 16 - s;
    else if (s < 19)  b = 18 - s;
    else if (s < 31)  b = 33 - s;
    else if (s == 31) b = 0;
    else if (s < 48)  b = 63 - s;
    else              b = s - 32;
    return BIT_W'(b);
  endfunction

  always_comb begin
    set_hi = '0;
    set_lo = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_req[s]) begin
        if (in_upper(s)) set_hi[bit_of(s)] = 1'b1;
        else             set_lo[bit_of(s)] = 1'b1;
      end
    end
  end

  wire wr_pend_hi = bus_wr && bus_addr == A_PEND_HI;
  wire wr_pend_lo = bus_wr && bus_addr == A_PEND_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_hi <= '0;
      pend_lo <= '0;
      mask_hi <= '0;
      mask_lo <= '0;
    end else begin
      pend_hi <= (pend_hi & ~(wr_pend_hi ? bus_wdata : '0)) | set_hi;
      pend_lo <= (pend_lo & ~(wr_pend_lo ? bus_wdata : '0)) | set_lo;
      if (bus_wr && bus_addr == A_MASK_HI) mask_hi <= bus_wdata;
      if (bus_wr && bus_addr == A_MASK_LO) mask_lo <= bus_wdata;
    end
  end

  wire [REG_W-1:0] act_hi = pend_hi & mask_hi;
  wire [REG_W-1:0] act_lo = pend_lo & mask_lo;

  always_comb begin
    vec_num = '0;
    for (int s = NSRC - 1; s >= 1; s--) begin
      if (in_upper(s) ? act_hi[bit_of(s)] : act_lo[bit_of(s)])
        vec_num = VEC_W'(s);
    end
  end

  assign irq_out = |{act_hi, act_lo};

  always_comb begin
    case (bus_addr)
      A_PEND_HI: bus_rdata = pend_hi;
      A_PEND_LO: bus_rdata = pend_lo;
      A_MASK_HI: bus_rdata = mask_hi;
      A_MASK_LO: bus_rdata = mask_lo;
      A_VECTOR:  bus_rdata = {vec_num, {(REG_W-VEC_W){1'b0}}};
      default:   bus_rdata = '0;
    endcase
  end
endmodule

module scram_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [63:0] src_req,
  input logic [2:0]  bus_addr,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq_out,
  input logic [31:0] pend_hi,
  input logic [31:0] pend_lo,
  input logic [31:0] mask_hi,
  input logic [31:0] mask_lo
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pend_hi == 0 && pend_lo == 0 && mask_hi == 0 && mask_lo == 0 && !irq_out));

  // R8
  vec_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4 && bus_rdata[31:26] != 0) |-> irq_out);

  // R8
  vec_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4) |-> (bus_rdata[25:0] == 0));

  // R4
  mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd2) |=> (mask_hi == $past(bus_wdata)));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && bus_wdata == 32'hFFFF_FFFF && src_req == 0) |=> (pend_hi == 0));

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_req[5] |=> pend_hi[11]);

  // R7
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_hi == 0 && mask_lo == 0) |-> !irq_out);
endmodule

bind scram_intc scram_intc_chk i_scram_intc_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq_out(irq_out), .pend_hi(pend_hi), .pend_lo(pend_lo),
  .mask_hi(mask_hi), .mask_lo(mask_lo)
);

// File: tb/test_scram_intc.sv
module test_scram_intc;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_req = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  scram_intc i_scram_intc (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  function automatic bit exp_upper(int s);
    return (s / 16) % 2 == 0;
  endfunction

  function automatic int exp_bit(int s);
    case (s) inside
      0, 31:    return 0;
      [1:15]:   return 16 - s;
      [16:18]:  return 18 - s;
      [19:30]:  return 33 - s;
      [32:47]:  return 63 - s;
      default:  return s - 32;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] v);
    @(negedge clk);
    src_req = v;
    @(negedge clk);
    src_req = '0;
  endtask

  task automatic clear_all;
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check($sformatf("R1 reg %0d", a), d, 0);
    end
    check("R1 irq", {31'd0, irq_out}, 0);
  endtask

  task automatic t_mapping;
    logic [31:0] h, l, eh, el;
    for (int s = 0; s < 64; s++) begin
      pulse(64'd1 << s);
      rd(3'd0, h);
      rd(3'd1, l);
      eh = exp_upper(s) ? (32'd1 << exp_bit(s)) : 0;
      el = exp_upper(s) ? 0 : (32'd1 << exp_bit(s));
      check($sformatf("R2 R3 R6 src %0d hi", s), h, eh);
      check($sformatf("R2 R3 src %0d lo", s), l, el);
      check("R4 masked no irq", {31'd0, irq_out}, 0);
      clear_all();
    end
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    pulse((64'd1 << 1) | (64'd1 << 2));
    wr(3'd0, 32'd0);
    rd(3'd0, d);
    check("R5 zero write", d, 32'h0000_C000);
    wr(3'd0, 32'h0000_8000);
    rd(3'd0, d);
    check("R5 partial clear", d, 32'h0000_4000);
    clear_all();
    rd(3'd0, d);
    check("R5 all ones", d, 0);
  endtask

  task automatic t_mask_rw;
    logic [31:0] d;
    wr(3'd2, 32'hA5A5_0F0F);
    rd(3'd2, d);
    check("R4 mask hi", d, 32'hA5A5_0F0F);
    wr(3'd3, 32'h1234_5678);
    rd(3'd3, d);
    check("R4 mask lo", d, 32'h1234_5678);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    pulse((64'd1 << 40) | (64'd1 << 20) | (64'd1 << 33));
    rd(3'd4, d);
    check("R8 lowest wins", d, 32'd20 << 26);
    check("R7 irq high", {31'd0, irq_out}, 1);
    wr(3'd1, 32'd1 << 13);
    rd(3'd4, d);
    check("R8 next source", d, 32'd33 << 26);
    wr(3'd2, ~(32'd1 << 30));
    rd(3'd4, d);
    check("R4 R8 mask blocks", d, 32'd40 << 26);
    clear_all();
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd4, d);
    check("R8 empty", d, 0);
    check("R7 irq low", {31'd0, irq_out}, 0);
    pulse(64'd1 << 31);
    rd(3'd4, d);
    check("R3 R8 shared bit", d, 32'd18 << 26);
    clear_all();
    pulse(64'd1);
    rd(3'd4, d);
    check("R8 source 0 vector", d, 0);
    check("R7 source 0 irq", {31'd0, irq_out}, 1);
    clear_all();
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk);
    src_req = 64'd1 << 7;
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr = 1'b0; src_req = '0;
    rd(3'd0, d);
    check("R9 set beats clear", d, 32'd1 << 9);
    clear_all();
    rd(3'd0, d);
    check("R5 R9 later clear", d, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mapping();
    t_w1c();
    t_mask_rw();
    t_priority();
    t_set_wins();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule